// File: doc/BRIEF.md
# Quad-Word Load-Linked / Store-Conditional Reservation Monitor

This block holds one load-linked reservation for a single hart and decides whether a paired store-conditional may commit. A load-linked request marks a 16-byte block of physical memory as reserved. A later store-conditional carries an address and two 64-bit halves. If the reservation still holds for that block and the address is 16-byte aligned, the block issues one 128-bit write, with the high half in the upper 64 bits. It then returns the 64-bit status value 1, which goes back to the register that held the low half. In every other case memory is left untouched and the status is 0.

Several events end the reservation: an exception or exception return, a remote snoop invalidate that hits the block, and an ordinary local store that hits the block. Ordinary local loads are observed but never end the reservation. The pipeline supplies the store-conditional address directly from the base register, so no offset is added. Address translation, caches and instruction decode are handled outside this block.

A four-state controller sequences each store-conditional:
- `ST_IDLE` is the only state that accepts a request (`sc_ready` high).
- `IDLE→WRITE` is taken when the request passes.
- `IDLE→FAIL` is taken when the request is misaligned or has no matching reservation.
- In `ST_WRITE` the controller holds the memory write until it is accepted. `WRITE→PASS` is taken on the accepting handshake.
- `ST_PASS` and `ST_FAIL` each present the result for one cycle and then return to `ST_IDLE`.

Top module: `quad_resv_monitor`

## Requirements
- R1: After reset `sc_ready` is 1, and `mem_wvalid`, `res_valid` and `addr_err` are 0.
- R2: A load-linked request records bits [63:4] of `ll_addr` and makes the reservation valid, replacing any earlier reservation. The value of bits [3:0] does not matter.
- R3: A store-conditional accepted with a valid reservation, a matching bits [63:4] and bits [3:0] equal to 0 produces exactly one memory write. The write address is `sc_addr` and the write data is `{sc_hi, sc_lo}`, with `sc_hi` in bits [127:64].
- R4: A failing store-conditional produces no memory write and returns `res_data` equal to 0.
- R5: On success `res_data` is 1, with bits [63:1] zero. `res_valid` is a single-cycle pulse. It comes one cycle after the write handshake (`mem_wvalid` and `mem_wready` both 1), or one cycle after the request is accepted when the request fails.
- R6: Every accepted store-conditional makes the reservation invalid, whether it passes or fails.
- R7: A store-conditional whose address bits [3:0] are not zero fails with `addr_err` set to 1 during its result cycle. `addr_err` is never 1 outside a failing result cycle.
- R8: An `exc_event` pulse makes the reservation invalid.
- R9: A snoop invalidate whose address bits [63:4] match the reserved block makes the reservation invalid. A snoop to any other block has no effect.
- R10: A local store (`loc_valid` with `loc_is_store` = 1) to the reserved block makes the reservation invalid. A local load (`loc_is_store` = 0) has no effect.
- R11: When a load-linked request arrives in the same cycle as any invalidating event, the reservation ends up invalid.
- R12: While `mem_wvalid` is 1 and `mem_wready` is 0, the write address and write data stay stable and `sc_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-linked request |
| ll_addr | input | 64 | Load-linked physical address |
| sc_valid | input | 1 | Store-conditional request |
| sc_ready | output | 1 | Controller can accept a store-conditional |
| sc_addr | input | 64 | Store-conditional physical address |
| sc_hi | input | 64 | High double-word of the paired store |
| sc_lo | input | 64 | Low double-word of the paired store |
| exc_event | input | 1 | Exception or exception return taken |
| snp_valid | input | 1 | Remote invalidate snoop |
| snp_addr | input | 64 | Snoop address |
| loc_valid | input | 1 | Local ordinary access observed |
| loc_is_store | input | 1 | Local access is a store (1) or a load (0) |
| loc_addr | input | 64 | Local access address |
| mem_wvalid | output | 1 | 128-bit write request |
| mem_wready | input | 1 | Memory accepts the write |
| mem_waddr | output | 64 | Write address |
| mem_wdata | output | 128 | Write data, high half in the upper bits |
| res_valid | output | 1 | Status result valid |
| res_data | output | 64 | Status value, 1 on success and 0 on failure |
| addr_err | output | 1 | Misaligned store-conditional address |

## Verification
A sweep runs every combination of the load-linked byte offset and the store-conditional byte offset inside one 16-byte block. This separates the block-granular reservation match from the alignment rule: only a zero store offset may commit, whatever the load offset was. Each invalidating source is also tried twice, once aimed at the reserved block and once aimed at a neighbouring block. This separates a true hit from a mere event, and a separate check confirms that local loads are harmless. Memory stalls of zero to three cycles check that the write is held and that the result latency follows the handshake. Back-to-back store-conditionals, replaced reservations and a load-linked request that coincides with an exception cover the clear-on-use and priority rules.

// File: rtl/qrm_pkg.sv
package qrm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_PASS  = 2'd2,
        ST_FAIL  = 2'd3
    } qrm_state_e;

    localparam int QRM_SRC_SNOOP = 0;
    localparam int QRM_SRC_LOCAL = 1;
    localparam int QRM_SRC_SC    = 2;
    localparam int QRM_NUM_SRC   = 3;
endpackage

// File: rtl/qrm_blkcmp.sv
module qrm_blkcmp #(
    parameter int ADDR_W   = 64,
    parameter int GRAN_LSB = 4
) (
    input  logic                       en,
    input  logic [ADDR_W-1:GRAN_LSB]   probe_blk,
    input  logic [ADDR_W-1:GRAN_LSB]   resv_blk,
    output logic                       hit
);
    always_comb begin
        hit = en && (probe_blk == resv_blk);
    end
endmodule

// File: rtl/qrm_resv.sv
module qrm_resv #(
    parameter int ADDR_W   = 64,
    parameter int GRAN_LSB = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ll_set,
    input  logic [ADDR_W-1:GRAN_LSB] ll_blk,
    input  logic                     sc_take,
    input  logic                     exc_event,
    input  logic                     snp_hit,
    input  logic                     st_hit,
    output logic                     resv_vld,
    output logic [ADDR_W-1:GRAN_LSB] resv_blk
);
    logic kill;

    always_comb begin
        kill = sc_take | exc_event | snp_hit | st_hit;
    end

    // Invalidating events take priority over a same-cycle load-linked request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_vld <= 1'b0;
        end else if (kill) begin
            resv_vld <= 1'b0;
        end else if (ll_set) begin
            resv_vld <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_blk <= '0;
        end else if (ll_set) begin
            resv_blk <= ll_blk;
        end
    end
endmodule

// File: rtl/qrm_ctrl.sv
module qrm_ctrl
    import qrm_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DW       = 64,
    parameter int GRAN_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [DW-1:0]     sc_hi,
    input  logic [DW-1:0]     sc_lo,
    input  logic              sc_hit,
    output logic              sc_ready,
    output logic              sc_take,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [2*DW-1:0]   mem_wdata,
    output logic              res_valid,
    output logic [DW-1:0]     res_data,
    output logic              addr_err
);
    localparam logic [DW-1:0] RES_OK = {{(DW-1){1'b0}}, 1'b1};

    qrm_state_e state_q, state_d;
    logic       aligned;
    logic       err_q;

    always_comb begin
        aligned = (sc_addr[GRAN_LSB-1:0] == '0);
        sc_take = sc_valid && (state_q == ST_IDLE);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sc_valid) begin
                    state_d = (aligned && sc_hit) ? ST_WRITE : ST_FAIL;
                end
            end
            ST_WRITE: begin
                if (mem_wready) begin
                    state_d = ST_PASS;
                end
            end
            ST_PASS:  state_d = ST_IDLE;
            ST_FAIL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_waddr <= '0;
            mem_wdata <= '0;
            err_q     <= 1'b0;
        end else if (sc_take) begin
            mem_waddr <= sc_addr;
            mem_wdata <= {sc_hi, sc_lo};
            err_q     <= !aligned;
        end
    end

    always_comb begin
        sc_ready   = 1'b0;
        mem_wvalid = 1'b0;
        res_valid  = 1'b0;
        res_data   = '0;
        addr_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:  sc_ready = 1'b1;
            ST_WRITE: mem_wvalid = 1'b1;
            ST_PASS: begin
                res_valid = 1'b1;
                res_data  = RES_OK;
            end
            ST_FAIL: begin
                res_valid = 1'b1;
                addr_err  = err_q;
            end
            default: sc_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/quad_resv_monitor.sv
module quad_resv_monitor
    import qrm_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DW       = 64,
    parameter int GRAN_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    output logic              sc_ready,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [DW-1:0]     sc_hi,
    input  logic [DW-1:0]     sc_lo,
    input  logic              exc_event,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              loc_valid,
    input  logic              loc_is_store,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [2*DW-1:0]   mem_wdata,
    output logic              res_valid,
    output logic [DW-1:0]     res_data,
    output logic              addr_err
);
    localparam int BLK_W = ADDR_W - GRAN_LSB;

    logic                     resv_vld;
    logic [ADDR_W-1:GRAN_LSB] resv_blk;
    logic                     sc_take;
    logic [QRM_NUM_SRC-1:0]   src_en;
    logic [QRM_NUM_SRC-1:0]   src_hit;
    logic [BLK_W-1:0]         src_blk [QRM_NUM_SRC];

    always_comb begin
        src_en[QRM_SRC_SNOOP]  = resv_vld && snp_valid;
        src_en[QRM_SRC_LOCAL]  = resv_vld && loc_valid && loc_is_store;
        src_en[QRM_SRC_SC]     = resv_vld;
        src_blk[QRM_SRC_SNOOP] = snp_addr[ADDR_W-1:GRAN_LSB];
        src_blk[QRM_SRC_LOCAL] = loc_addr[ADDR_W-1:GRAN_LSB];
        src_blk[QRM_SRC_SC]    = sc_addr[ADDR_W-1:GRAN_LSB];
    end

    for (genvar g = 0; g < QRM_NUM_SRC; g++) begin : g_cmp
        qrm_blkcmp #(
            .ADDR_W   (ADDR_W),
            .GRAN_LSB (GRAN_LSB)
        ) u_cmp (
            .en        (src_en[g]),
            .probe_blk (src_blk[g]),
            .resv_blk  (resv_blk),
            .hit       (src_hit[g])
        );
    end

    qrm_resv #(
        .ADDR_W   (ADDR_W),
        .GRAN_LSB (GRAN_LSB)
    ) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .ll_set    (ll_valid),
        .ll_blk    (ll_addr[ADDR_W-1:GRAN_LSB]),
        .sc_take   (sc_take),
        .exc_event (exc_event),
        .snp_hit   (src_hit[QRM_SRC_SNOOP]),
        .st_hit    (src_hit[QRM_SRC_LOCAL]),
        .resv_vld  (resv_vld),
        .resv_blk  (resv_blk)
    );

    qrm_ctrl #(
        .ADDR_W   (ADDR_W),
        .DW       (DW),
        .GRAN_LSB (GRAN_LSB)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sc_valid   (sc_valid),
        .sc_addr    (sc_addr),
        .sc_hi      (sc_hi),
        .sc_lo      (sc_lo),
        .sc_hit     (src_hit[QRM_SRC_SC]),
        .sc_ready   (sc_ready),
        .sc_take    (sc_take),
        .mem_wvalid (mem_wvalid),
        .mem_wready (mem_wready),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .addr_err   (addr_err)
    );
endmodule

// File: rtl/qrm_checker.sv
module qrm_checker #(
    parameter int ADDR_W   = 64,
    parameter int DW       = 64,
    parameter int GRAN_LSB = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sc_valid,
    input logic              sc_ready,
    input logic              mem_wvalid,
    input logic              mem_wready,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [2*DW-1:0]   mem_wdata,
    input logic              res_valid,
    input logic [DW-1:0]     res_data,
    input logic              addr_err,
    input logic              resv_vld
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    a_r12_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata));

    a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> !sc_ready);

    a_r5_ok_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid && mem_wready |=> res_valid && (res_data == ONE));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r4_status_values: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data == ONE) || (res_data == '0));

    a_r7_err_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> res_valid && (res_data == '0));

    a_r3_aligned_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> (mem_waddr[GRAN_LSB-1:0] == '0));

    a_r6_clear_on_sc: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && sc_ready |=> !resv_vld);
endmodule

bind quad_resv_monitor qrm_checker #(
    .ADDR_W   (ADDR_W),
    .DW       (DW),
    .GRAN_LSB (GRAN_LSB)
) u_chk (.*);

// File: tb/quad_resv_monitor_test.sv
`timescale 1ns/1ps
module quad_resv_monitor_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ll_valid = 1'b0;
    logic [63:0]  ll_addr = '0;
    logic         sc_valid = 1'b0;
    logic         sc_ready;
    logic [63:0]  sc_addr = '0;
    logic [63:0]  sc_hi = '0;
    logic [63:0]  sc_lo = '0;
    logic         exc_event = 1'b0;
    logic         snp_valid = 1'b0;
    logic [63:0]  snp_addr = '0;
    logic         loc_valid = 1'b0;
    logic         loc_is_store = 1'b0;
    logic [63:0]  loc_addr = '0;
    logic         mem_wvalid;
    logic         mem_wready = 1'b0;
    logic [63:0]  mem_waddr;
    logic [127:0] mem_wdata;
    logic         res_valid;
    logic [63:0]  res_data;
    logic         addr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    quad_resv_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_ready(sc_ready),
        .sc_addr(sc_addr), .sc_hi(sc_hi), .sc_lo(sc_lo),
        .exc_event(exc_event),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .loc_valid(loc_valid), .loc_is_store(loc_is_store), .loc_addr(loc_addr),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .res_valid(res_valid), .res_data(res_data), .addr_err(addr_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_ll(input logic [63:0] a);
        @(negedge clk); ll_valid = 1'b1; ll_addr = a;
        @(negedge clk); ll_valid = 1'b0;
    endtask

    task automatic do_exc();
        @(negedge clk); exc_event = 1'b1;
        @(negedge clk); exc_event = 1'b0;
    endtask

    task automatic do_snoop(input logic [63:0] a);
        @(negedge clk); snp_valid = 1'b1; snp_addr = a;
        @(negedge clk); snp_valid = 1'b0;
    endtask

    task automatic do_local(input logic [63:0] a, input bit is_st);
        @(negedge clk); loc_valid = 1'b1; loc_is_store = is_st; loc_addr = a;
        @(negedge clk); loc_valid = 1'b0;
    endtask

    // Issue one store-conditional and check the full outcome against the expectation.
    task automatic check_sc(input string req, input logic [63:0] a, input logic [63:0] hi,
                            input logic [63:0] lo, input int dly, input bit exp_ok, input bit exp_ae);
        bit           wrote = 0;
        bit           got = 0;
        int           n = 0;
        int           lat = -1;
        logic [63:0]  wa = '0;
        logic [127:0] wd = '0;
        logic [63:0]  r = '0;
        logic         ae = 1'b0;
        @(negedge clk);
        chk(sc_ready, req, "sc_ready before request", {127'd0, sc_ready}, 128'd1);
        sc_valid = 1'b1; sc_addr = a; sc_hi = hi; sc_lo = lo;
        @(negedge clk);
        sc_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (res_valid) begin
                got = 1; lat = i; r = res_data; ae = addr_err;
                mem_wready = 1'b0;
                break;
            end
            if (mem_wvalid) begin
                if (!sc_ready) ; else chk(0, "R12", "sc_ready while writing", 128'd1, 128'd0);
                if (wrote) begin
                    chk(mem_waddr == wa && mem_wdata == wd, "R12", "write held stable", mem_wdata, wd);
                end
                wrote = 1; wa = mem_waddr; wd = mem_wdata;
                mem_wready = (n >= dly);
                n++;
            end
            @(negedge clk);
        end
        chk(got, req, "result returned", {127'd0, got}, 128'd1);
        if (exp_ok) begin
            chk(wrote, "R3", "write issued", {127'd0, wrote}, 128'd1);
            chk(wa == a, "R3", "write address", {64'd0, wa}, {64'd0, a});
            chk(wd == {hi, lo}, "R3", "write data", wd, {hi, lo});
            chk(r == 64'd1, "R5", "success status", {64'd0, r}, 128'd1);
            chk(lat == dly + 1, "R5", "success latency", lat, dly + 1);
            chk(ae == 1'b0, "R7", "no addr_err on success", {127'd0, ae}, 128'd0);
        end else begin
            chk(!wrote, "R4", "no write on failure", {127'd0, wrote}, 128'd0);
            chk(r == 64'd0, req, "failure status", {64'd0, r}, 128'd0);
            chk(lat == 0, "R5", "failure latency", lat, 0);
            chk(ae == exp_ae, "R7", "addr_err flag", {127'd0, ae}, {127'd0, exp_ae});
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] blk;
        repeat (3) @(negedge clk);
        chk(sc_ready == 1'b1, "R1", "reset sc_ready", {127'd0, sc_ready}, 128'd1);
        chk(!mem_wvalid && !res_valid && !addr_err, "R1", "reset outputs",
            {125'd0, mem_wvalid, res_valid, addr_err}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sc_ready && !mem_wvalid && !res_valid && !addr_err, "R1", "outputs after reset release",
            {124'd0, sc_ready, mem_wvalid, res_valid, addr_err}, 128'd8);

        // R4: no reservation at all
        check_sc("R4", 64'h0000_0000_0000_1000, 64'h11, 64'h22, 0, 0, 0);

        // R2/R3/R7: sweep load offset and store offset inside one block
        for (int lo_off = 0; lo_off < 16; lo_off++) begin
            for (int so_off = 0; so_off < 16; so_off++) begin
                blk = 64'h0000_4000_0000_0000 + 64'((lo_off * 16 + so_off) * 16);
                do_ll(blk + 64'(lo_off));
                check_sc(so_off == 0 ? "R2" : "R7", blk + 64'(so_off),
                         {48'hABCD, 8'(lo_off), 8'(so_off)}, ~blk, 0, so_off == 0, so_off != 0);
            end
        end

        // R5/R12: memory stalls
        for (int d = 0; d < 4; d++) begin
            do_ll(64'h0000_0000_0000_2000 + 64'(d * 16));
            check_sc("R12", 64'h0000_0000_0000_2000 + 64'(d * 16), 64'hFFFF_0000_0000_0000 | 64'(d),
                     64'h0123_4567_89AB_CDEF, d, 1, 0);
        end

        // R6: second store-conditional after success, and after a misaligned failure
        do_ll(64'h3000);
        check_sc("R6", 64'h3000, 64'h1, 64'h2, 0, 1, 0);
        check_sc("R6", 64'h3000, 64'h1, 64'h2, 0, 0, 0);
        do_ll(64'h3100);
        check_sc("R6", 64'h3108, 64'h1, 64'h2, 0, 0, 1);
        check_sc("R6", 64'h3100, 64'h1, 64'h2, 0, 0, 0);

        // R2: replacement of an earlier reservation
        do_ll(64'h5000); do_ll(64'h6000);
        check_sc("R2", 64'h5000, 64'h7, 64'h8, 0, 0, 0);
        do_ll(64'h5000); do_ll(64'h6000);
        check_sc("R2", 64'h6000, 64'h7, 64'h8, 0, 1, 0);

        // R8: exception in between
        do_ll(64'h7000); do_exc();
        check_sc("R8", 64'h7000, 64'h9, 64'hA, 0, 0, 0);

        // R9: snoop hit vs miss
        do_ll(64'h8000); do_snoop(64'h800C);
        check_sc("R9", 64'h8000, 64'hB, 64'hC, 0, 0, 0);
        do_ll(64'h8000); do_snoop(64'h8010);
        check_sc("R9", 64'h8000, 64'hB, 64'hC, 0, 1, 0);

        // R10: local store hit, local store miss, local load hit
        do_ll(64'h9000); do_local(64'h9004, 1);
        check_sc("R10", 64'h9000, 64'hD, 64'hE, 0, 0, 0);
        do_ll(64'h9000); do_local(64'h8FF0, 1);
        check_sc("R10", 64'h9000, 64'hD, 64'hE, 0, 1, 0);
        do_ll(64'h9000); do_local(64'h9008, 0);
        check_sc("R10", 64'h9000, 64'hD, 64'hE, 0, 1, 0);

        // R11: load-linked coinciding with an exception
        @(negedge clk); ll_valid = 1'b1; ll_addr = 64'hA000; exc_event = 1'b1;
        @(negedge clk); ll_valid = 1'b0; exc_event = 1'b0;
        check_sc("R11", 64'hA000, 64'hF, 64'h10, 0, 0, 0);
        // R11: load-linked coinciding with a snoop hitting the old block
        do_ll(64'hB000);
        @(negedge clk); ll_valid = 1'b1; ll_addr = 64'hC000; snp_valid = 1'b1; snp_addr = 64'hB000;
        @(negedge clk); ll_valid = 1'b0; snp_valid = 1'b0;
        check_sc("R11", 64'hC000, 64'hF, 64'h10, 0, 0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule